// File: doc/BRIEF.md
# Link and Activity Indicator Driver

This block turns a network port's link state and its per-packet events into three indicator outputs. A link-good level and two single-cycle event strobes come in, one for transmitted packets and one for received packets. Three LED levels go out. The first shows link state. The second lights for a fixed hold window after each packet. The third is a merged indicator for packages that have only one LED pin: it shows link as a steady level and goes dark for the hold window after every packet.

The hold window is set by the parameter `HOLD_CYCLES`. Its default of 1,000,000 cycles gives 50 ms at a 20 MHz clock. A packet that arrives while a window is already open restarts the window; pulses are not queued. A control word carries one enable bit per output, and a disabled output is held low. The hold timer keeps running no matter which outputs are enabled.

All inputs and outputs are plain control levels with no handshake. Every output is registered, so each one reflects its inputs one clock later.

Top module: `led_indicator_drv`

## Requirements
- R1: With `led_en[0]` set, `led_link` equals the `link_good` value sampled at the previous rising edge.
- R2: A packet event is sampled at rising edge N. With no further events, and with `led_en[1]` set, `led_act` is high after edges N+1 through N+HOLD_CYCLES and low after edge N+HOLD_CYCLES+1.
- R3: A packet event that arrives while a hold window is open restarts the window from its full length. The window then ends HOLD_CYCLES+1 edges after the newest event.
- R4: With link good, no open hold window and `led_en[2]` set, `led_combo` is high.
- R5: With link good, `led_combo` is low during the same cycles in which R2 makes `led_act` high, and returns high once the window closes.
- R6: After an edge at which `link_good` was low, `led_combo` is low, whatever the packet events.
- R7: Bits 0, 1 and 2 of `led_en` enable `led_link`, `led_act` and `led_combo` respectively. If a bit was clear at the previous edge, its output is low.
- R8: Disabling an output does not stop the hold timer. If `led_act` is re-enabled partway through a window, it is high for the rest of that window and low after it.
- R9: While `rst_n` is low, all three outputs are low and no hold window is open.
- R10: `tx_evt` and `rx_evt` each start a window. When both are high in the same cycle, they act as one event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 20 MHz nominal |
| rst_n | input | 1 | Active-low synchronous reset |
| link_good | input | 1 | High while valid link pulses are seen |
| tx_evt | input | 1 | One-cycle strobe per transmitted packet |
| rx_evt | input | 1 | One-cycle strobe per received packet |
| led_en | input | 3 | Per-output enable: bit 0 link, bit 1 activity, bit 2 combined |
| led_link | output | 1 | Link indicator |
| led_act | output | 1 | Activity indicator |
| led_combo | output | 1 | Combined link/activity indicator |

## Verification
The bench builds the block with `HOLD_CYCLES` set to 16 in place of one million. At that length a full hold window, both of its edges, restarts from inside the window and re-enables part-way through it all fit in a few dozen cycles. Thousands of random cycles therefore cover many complete windows, many overlapping windows and many link drops during a window.

// File: rtl/led_drv_pkg.sv
package led_drv_pkg;
  localparam int NUM_LEDS = 3;

  typedef enum int {
    LED_LINK  = 0,
    LED_ACT   = 1,
    LED_COMBO = 2
  } led_idx_e;
endpackage

// File: rtl/led_hold_timer.sv
module led_hold_timer #(
  parameter int HOLD_CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  output logic active
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(HOLD_CYCLES);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (trigger) begin
      remain_q <= LOAD_VAL;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign active = (remain_q != '0);
endmodule

// File: rtl/led_out_reg.sv
module led_out_reg #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  input  logic [N-1:0] en,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= raw[i] & en[i];
    end
  end
endmodule

// File: rtl/led_indicator_drv.sv
module led_indicator_drv
  import led_drv_pkg::*;
#(
  parameter int HOLD_CYCLES = 1000000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                link_good,
  input  logic                tx_evt,
  input  logic                rx_evt,
  input  logic [NUM_LEDS-1:0] led_en,
  output logic                led_link,
  output logic                led_act,
  output logic                led_combo
);
  logic                pkt_seen;
  logic                window_open;
  logic [NUM_LEDS-1:0] raw_lvl;
  logic [NUM_LEDS-1:0] led_q;

  assign pkt_seen = tx_evt | rx_evt;

  led_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .trigger (pkt_seen),
    .active  (window_open)
  );

  always_comb begin
    raw_lvl            = '0;
    raw_lvl[LED_LINK]  = link_good;
    raw_lvl[LED_ACT]   = window_open;
    raw_lvl[LED_COMBO] = link_good & ~window_open;
  end

  led_out_reg #(.N(NUM_LEDS)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   (raw_lvl),
    .en    (led_en),
    .q     (led_q)
  );

  assign led_link  = led_q[LED_LINK];
  assign led_act   = led_q[LED_ACT];
  assign led_combo = led_q[LED_COMBO];
endmodule

// File: rtl/led_indicator_drv_chk.sv
module led_indicator_drv_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       link_good,
  input logic       tx_evt,
  input logic       rx_evt,
  input logic [2:0] led_en,
  input logic       led_link,
  input logic       led_act,
  input logic       led_combo
);
  AST_RESET_DARK: assert property (@(posedge clk)
    !rst_n |=> (!led_link && !led_act && !led_combo)); // R9

  AST_LINK_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    led_en[0] |=> (led_link == $past(link_good))); // R1

  AST_ACT_LIGHTS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_evt || rx_evt) ##1 led_en[1] |=> led_act); // R2

  AST_COMBO_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_evt || rx_evt) |=> ##1 !led_combo); // R5

  AST_COMBO_NOLINK: assert property (@(posedge clk) disable iff (!rst_n)
    !link_good |=> !led_combo); // R6

  AST_LINK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !led_en[0] |=> !led_link); // R7

  AST_ACT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !led_en[1] |=> !led_act); // R7

  AST_COMBO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !led_en[2] |=> !led_combo); // R7
endmodule

bind led_indicator_drv led_indicator_drv_chk u_chk (.*);

// File: tb/led_indicator_drv_tb.sv
module led_indicator_drv_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       link_good = 1'b0;
  logic       tx_evt = 1'b0;
  logic       rx_evt = 1'b0;
  logic [2:0] led_en = 3'b000;
  logic       led_link, led_act, led_combo;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference state, derived from the requirements
  int   m_remain = 0;
  logic e_link = 1'b0, e_act = 1'b0, e_combo = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  led_indicator_drv #(.HOLD_CYCLES(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .link_good(link_good), .tx_evt(tx_evt),
    .rx_evt(rx_evt), .led_en(led_en), .led_link(led_link),
    .led_act(led_act), .led_combo(led_combo)
  );

  function automatic int next_remain(int cur, bit evt);
    if (evt) return HOLD;
    return (cur > 0) ? cur - 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_remain <= 0;
      e_link <= 0; e_act <= 0; e_combo <= 0;
    end else begin
      e_link   <= led_en[0] & link_good;
      e_act    <= led_en[1] & (m_remain > 0);
      e_combo  <= led_en[2] & link_good & (m_remain == 0);
      m_remain <= next_remain(m_remain, tx_evt | rx_evt);
    end
  end

  task automatic check(string req, string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, got, exp, $time);
    end
  endtask

  task automatic step(string rl, string ra, string rc);
    @(negedge clk);
    check(rl, "led_link", led_link, e_link);
    check(ra, "led_act", led_act, e_act);
    check(rc, "led_combo", led_combo, e_combo);
    tx_evt = 1'b0;
    rx_evt = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R9", "led_link", led_link, 1'b0);
    check("R9", "led_act", led_act, 1'b0);
    check("R9", "led_combo", led_combo, 1'b0);
    rst_n = 1'b1;
    led_en = 3'b111;
    link_good = 1'b1;
    repeat (4) step("R1", "R2", "R4");

    // single packet, full window
    tx_evt = 1'b1;
    repeat (HOLD + 4) step("R1", "R2", "R5");

    // restart inside the window
    rx_evt = 1'b1;
    repeat (6) step("R1", "R3", "R3");
    tx_evt = 1'b1;
    repeat (HOLD + 4) step("R1", "R3", "R3");

    // simultaneous tx and rx
    tx_evt = 1'b1; rx_evt = 1'b1;
    repeat (HOLD + 3) step("R1", "R10", "R10");

    // link failure with traffic
    link_good = 1'b0;
    step("R1", "R2", "R6");
    for (int i = 0; i < 30; i++) begin
      tx_evt = (i % 5 == 0);
      step("R1", "R2", "R6");
    end
    link_good = 1'b1;
    repeat (HOLD + 3) step("R1", "R2", "R4");

    // disable activity mid-window, then re-enable
    tx_evt = 1'b1;
    led_en = 3'b101;
    repeat (5) step("R7", "R7", "R8");
    led_en = 3'b111;
    repeat (HOLD) step("R7", "R8", "R8");
    led_en = 3'b000;
    rx_evt = 1'b1;
    repeat (4) step("R7", "R7", "R7");
    led_en = 3'b111;
    repeat (HOLD) step("R1", "R8", "R5");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      tx_evt    = ($urandom % 20) == 0;
      rx_evt    = ($urandom % 25) == 0;
      if (($urandom % 40) == 0) link_good = ~link_good;
      if (($urandom % 60) == 0) led_en = 3'($urandom);
      step("R7", "R3", "R6");
    end

    // reset in the middle of a window
    tx_evt = 1'b1;
    step("R1", "R2", "R5");
    rst_n = 1'b0;
    step("R9", "R9", "R9");
    step("R9", "R9", "R9");
    rst_n = 1'b1;
    led_en = 3'b111;
    link_good = 1'b1;
    repeat (3) step("R1", "R9", "R4");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule